// File: doc/BRIEF.md
# SIMD Immediate Shift-Left Unit

This block decodes one 32-bit shift-left-by-immediate instruction word and applies it to a 128-bit source register value. It accepts two forms. The vector form works on a 64-bit or 128-bit datapath split into 8-, 16-, 32- or 64-bit lanes. The scalar form always works on one 64-bit lane. Both the lane size and the shift distance come from a single 7-bit packed immediate (`immh:immb`, with `immh` the upper four bits). The position of the highest set bit of `immh` picks the lane size.

Each lane is shifted left on its own. Zeros enter at the bottom of the lane, and bits that pass the top of the lane are lost. The block takes one instruction per clock. The result, a valid flag and an undefined-instruction flag appear one cycle after the input strobe, from a single register stage.

Top module: `simd_shl_unit`

## Requirements
- R1: An instruction is recognised only when bits [15:10] equal 010101 and bits [31:23] match a form. The vector form has bit31=0, bit29=0 and bits[28:23]=011110. The scalar form has bits[31:23]=010111110. An unrecognised word produces valid=0, undef=0 and a zero result.
- R2: In the vector form the lane width is 8, 16, 32 or 64 bits. The choice follows the highest set bit of immh = bits[22:19]: bit 0, 1, 2 or 3.
- R3: The shift distance is the unsigned 7-bit value of bits[22:16] minus the lane width.
- R4: Each lane is shifted left by itself. Zeros fill from the low end, and no bit moves into a neighbouring lane.
- R5: In the vector form, bit 30 selects a 128-bit datapath when 1 and a 64-bit datapath when 0. With the 64-bit datapath, result bits [127:64] are zero.
- R6: A vector-form word with immh=0000 gives valid=0, undef=0 and a zero result.
- R7: A vector-form word with immh[3]=1 and bit30=0 raises undef.
- R8: The scalar form shifts one 64-bit lane by bits[22:16] minus 64, with bits [127:64] of the result zero. It raises undef when immh[3]=0.
- R9: While undef is high, valid is low and the result is zero.
- R10: Outputs reflect the instruction strobed by inValid one clock earlier. A cycle with inValid low clears valid, undef and result on the next clock.
- R11: A synchronous active-high reset clears valid, undef and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| srcData | input | 128 | Source register value |
| outValid | output | 1 | Result is a valid shift result |
| outUndef | output | 1 | Reserved or undefined encoding |
| result | output | 128 | Shifted value |

## Verification
The hardest situation to reach is a shift at the very top of a lane, where a set bit would move into the next lane if the lanes were not isolated. It takes a source pattern with set bits near each lane's upper edge, combined with the largest legal shift for that lane size. The bench reaches it by sweeping all 128 packed-immediate values under each of the three forms. Each source pattern is dense in both halves, and the expected result is rebuilt bit by bit from the lane width and shift distance.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;
  localparam int DATA_W   = 128;
  localparam int INSTR_W  = 32;
  localparam int IMM_W    = 7;
  localparam int SHIFT_W  = 6;
  localparam int SIZE_W   = 2;
  localparam int NUM_SIZES = 4;

  localparam logic [5:0] OPC_SHL    = 6'b010101;
  localparam logic [5:0] VEC_CLASS  = 6'b011110;
  localparam logic [8:0] SCAL_CLASS = 9'b010111110;

  typedef struct packed {
    logic                load;
    logic                accept;
    logic                undef;
    logic                wide;
    logic [SIZE_W-1:0]   laneSel;
    logic [SHIFT_W-1:0]  shiftAmt;
  } ctrlStrobes_t;
endpackage

// File: rtl/simd_shl_ctrl.sv
module simd_shl_ctrl
  import simd_shl_pkg::*;
(
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  output ctrlStrobes_t       strobes
);
  logic [3:0]        immh;
  logic [IMM_W-1:0]  immField;
  logic              opOk, isVec, isScal, qBit, recognised, undefHit;
  logic [SIZE_W-1:0] topBit;
  logic [IMM_W-1:0]  laneBits;
  logic [IMM_W-1:0]  shiftFull;

  assign immh     = instr[22:19];
  assign immField = instr[22:16];
  assign qBit     = instr[30];
  assign opOk     = (instr[15:10] == OPC_SHL);
  assign isVec    = !instr[31] && !instr[29] && (instr[28:23] == VEC_CLASS);
  assign isScal   = (instr[31:23] == SCAL_CLASS);

  always_comb begin
    topBit = '0;
    for (int b = 0; b < 4; b++) begin
      if (immh[b]) topBit = SIZE_W'(b);
    end
  end

  always_comb begin
    laneBits = isScal ? IMM_W'(64) : (IMM_W'(8) << topBit);
    shiftFull = immField - laneBits;
  end

  assign recognised = opOk && ((isVec && immh != 4'b0000) || isScal);
  assign undefHit   = recognised && (isScal ? !immh[3] : (immh[3] && !qBit));

  always_comb begin
    strobes.load     = inValid;
    strobes.accept   = recognised && !undefHit;
    strobes.undef    = undefHit;
    strobes.wide     = isVec && qBit;
    strobes.laneSel  = isScal ? SIZE_W'(3) : topBit;
    strobes.shiftAmt = shiftFull[SHIFT_W-1:0];
  end
endmodule

// File: rtl/simd_shl_dp.sv
module simd_shl_dp
  import simd_shl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] srcData,
  output logic              outValid,
  output logic              outUndef,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] candidates [NUM_SIZES];
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] masked;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LANE_W = 8 << s;
    localparam int LANES  = DATA_W / LANE_W;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign candidates[s][l*LANE_W +: LANE_W] =
        srcData[l*LANE_W +: LANE_W] << strobes.shiftAmt[s+2:0];
    end
  end

  always_comb begin
    picked = candidates[strobes.laneSel];
    masked = strobes.wide ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst || !strobes.load) begin
      outValid <= 1'b0;
      outUndef <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobes.accept;
      outUndef <= strobes.undef;
      result   <= strobes.accept ? masked : '0;
    end
  end
endmodule

// File: rtl/simd_shl_unit.sv
module simd_shl_unit
  import simd_shl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [31:0]        instr,
  input  logic [127:0]       srcData,
  output logic               outValid,
  output logic               outUndef,
  output logic [127:0]       result
);
  ctrlStrobes_t strobes;

  simd_shl_ctrl ctrl_i (
    .inValid (inValid),
    .instr   (instr),
    .strobes (strobes)
  );

  simd_shl_dp dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .srcData  (srcData),
    .outValid (outValid),
    .outUndef (outUndef),
    .result   (result)
  );
endmodule

// File: rtl/simd_shl_checker.sv
module simd_shl_checker (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [31:0]  instr,
  input logic         outValid,
  input logic         outUndef,
  input logic [127:0] result
);
  logic vecForm;
  assign vecForm = !instr[31] && !instr[29] && (instr[28:23] == 6'b011110)
                   && (instr[15:10] == 6'b010101);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outUndef)); // R9

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    outUndef |-> (result == '0)); // R9

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid) |-> (!outValid && !outUndef && result == '0)); // R10

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && inValid && !instr[30]) |-> (result[127:64] == '0)); // R5

  AST_RESERVED_LANE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && inValid && vecForm && instr[22] && !instr[30]) |-> outUndef); // R7

  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && inValid && instr[15:10] != 6'b010101) |-> (!outValid && !outUndef)); // R1

  AST_EMPTY_IMMH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && inValid && vecForm && instr[22:19] == 4'b0000) |-> (!outValid && !outUndef)); // R6
endmodule

bind simd_shl_unit simd_shl_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .instr    (instr),
  .outValid (outValid),
  .outUndef (outUndef),
  .result   (result)
);

// File: tb/simd_shl_unit_tb_top.sv
module simd_shl_unit_tb_top;
  typedef struct packed {
    logic [31:0]  ins;
    logic [127:0] src;
    logic [127:0] exp;
    logic         v;
    logic         u;
  } tv_t;

  localparam int NTV = 11;
  localparam tv_t TBL [NTV] = '{
    // R2 R3: 8-bit lanes, shift 1, 128-bit
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd9,6'b010101,5'd1,5'd0}, {16{8'hFF}}, {16{8'hFE}}, 1'b1, 1'b0 },
    // R5: 8-bit lanes, 64-bit datapath
    '{ {1'b0,1'b0,1'b0,6'b011110,7'd9,6'b010101,5'd1,5'd0}, {16{8'hFF}}, {64'h0,{8{8'hFE}}}, 1'b1, 1'b0 },
    // R4: 16-bit lanes shift 4, top bit dropped
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd20,6'b010101,5'd1,5'd0}, {8{16'h8001}}, {8{16'h0010}}, 1'b1, 1'b0 },
    // R3: 32-bit lanes, maximum shift 31
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd63,6'b010101,5'd1,5'd0}, {4{32'h3}}, {4{32'h80000000}}, 1'b1, 1'b0 },
    // R2: 64-bit lanes, shift 0
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd64,6'b010101,5'd1,5'd0},
       128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D, 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D, 1'b1, 1'b0 },
    // R7: 64-bit lane with 64-bit datapath is reserved
    '{ {1'b0,1'b0,1'b0,6'b011110,7'd64,6'b010101,5'd1,5'd0}, {16{8'hFF}}, 128'h0, 1'b0, 1'b1 },
    // R6: immh zero is not this instruction
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd5,6'b010101,5'd1,5'd0}, {16{8'hFF}}, 128'h0, 1'b0, 1'b0 },
    // R8: scalar shift 8
    '{ {9'b010111110,7'd72,6'b010101,5'd1,5'd0},
       {64'hFFFFFFFFFFFFFFFF,64'h00FF000000000001}, {64'h0,64'hFF00000000000100}, 1'b1, 1'b0 },
    // R8: scalar without immh[3] is undefined
    '{ {9'b010111110,7'd56,6'b010101,5'd1,5'd0}, {16{8'hFF}}, 128'h0, 1'b0, 1'b1 },
    // R1: wrong opcode field
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd9,6'b010111,5'd1,5'd0}, {16{8'hFF}}, 128'h0, 1'b0, 1'b0 },
    // R2: immh 0101 selects 32-bit lanes, shift 13
    '{ {1'b0,1'b1,1'b0,6'b011110,7'd45,6'b010101,5'd1,5'd0}, {4{32'h0007FFFF}}, {4{32'hFFFFE000}}, 1'b1, 1'b0 }
  };

  function automatic string tagOf(input int i);
    case (i)
      0: return "R2";  1: return "R5";  2: return "R4";  3: return "R3";
      4: return "R2";  5: return "R7";  6: return "R6";  7: return "R8";
      8: return "R8";  9: return "R1";  default: return "R2";
    endcase
  endfunction

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [31:0]  instr;
  logic [127:0] srcData;
  logic         outValid;
  logic         outUndef;
  logic [127:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  simd_shl_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .srcData(srcData), .outValid(outValid), .outUndef(outUndef), .result(result)
  );

  task automatic refModel(input logic [31:0] ins, input logic [127:0] src,
                          output logic v, output logic u, output logic [127:0] res);
    logic [3:0] hi;
    int esize, sh, width, hb;
    bit vec, scal, known;
    hi   = ins[22:19];
    hb   = int'(ins[22:16]);
    vec  = (ins[31] == 1'b0) && (ins[29] == 1'b0) && (ins[28:23] == 6'b011110);
    scal = (ins[31:23] == 9'b010111110);
    known = (ins[15:10] == 6'b010101) && ((vec && hi != 0) || scal);
    esize = 64;
    if (vec) begin
      if (hi[3]) esize = 64;
      else if (hi[2]) esize = 32;
      else if (hi[1]) esize = 16;
      else esize = 8;
    end
    width = (vec && ins[30]) ? 128 : 64;
    sh = hb - esize;
    u = known && (scal ? !hi[3] : (hi[3] && !ins[30]));
    v = known && !u;
    res = '0;
    if (v) begin
      for (int i = 0; i < width; i++) begin
        if ((i % esize) >= sh) res[i] = src[i - sh];
      end
    end
  endtask

  task automatic check(input string tag, input logic ev, input logic eu, input logic [127:0] er);
    nChecks++;
    if (outValid !== ev || outUndef !== eu || result !== er) begin
      nFails++;
      $display("FAIL %s: got v=%b u=%b res=%h, expected v=%b u=%b res=%h",
               tag, outValid, outUndef, result, ev, eu, er);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [127:0] src);
    @(negedge clk);
    inValid = 1'b1; instr = ins; srcData = src;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic ev, eu;
    logic [127:0] er;
    rst = 1'b1; inValid = 1'b1; instr = TBL[0].ins; srcData = TBL[0].src;
    repeat (3) @(negedge clk);
    check("R11 reset", 1'b0, 1'b0, 128'h0);
    rst = 1'b0;

    for (int i = 0; i < NTV; i++) begin
      apply(TBL[i].ins, TBL[i].src);
      check(tagOf(i), TBL[i].v, TBL[i].u, TBL[i].exp);
    end

    // R10: result appears, then idle cycle clears it
    apply(TBL[0].ins, TBL[0].src);
    check("R10 latency", 1'b1, 1'b0, TBL[0].exp);
    inValid = 1'b0;
    @(negedge clk);
    check("R10 idle", 1'b0, 1'b0, 128'h0);

    // R9: undef after valid leaves no stale data
    apply(TBL[0].ins, TBL[0].src);
    apply(TBL[5].ins, TBL[5].src);
    check("R9 undef zero", 1'b0, 1'b1, 128'h0);

    // R11: reset mid-stream
    apply(TBL[2].ins, TBL[2].src);
    rst = 1'b1;
    @(negedge clk);
    check("R11 midstream", 1'b0, 1'b0, 128'h0);
    rst = 1'b0;

    // R4: sweep all immediates over three forms
    for (int f = 0; f < 3; f++) begin
      for (int hb = 0; hb < 128; hb++) begin
        logic [31:0] ins;
        logic [127:0] src;
        if (f == 2) ins = {9'b010111110, 7'(hb), 6'b010101, 5'd3, 5'd2};
        else        ins = {1'b0, f[0], 1'b0, 6'b011110, 7'(hb), 6'b010101, 5'd3, 5'd2};
        src = {64'hF7E1D2C3B4A59687 ^ 64'(hb * 977), 64'hFEDCBA9876543210 + 64'(hb)};
        refModel(ins, src, ev, eu, er);
        apply(ins, src);
        check("R4 sweep", ev, eu, er);
      end
    end

    inValid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule